// File: doc/BRIEF.md
# Memory-Mapped Integer Divider

This block is a hardware divider that a processor reaches through a small 32-bit register window. Software stores a dividend and a divisor, then collects a quotient and a remainder. Each operand register can be written through a signed address or an unsigned address. The address used picks the arithmetic mode, and every operand write starts a fresh division. The division runs as a fixed-latency iterative process. Each clock retires several quotient bits, so a full word finishes in a set number of cycles.

A status word has two flags. The first shows that a result is available. The second shows that the result has not yet been collected through the quotient register. The result registers are also writable. An interrupt handler can therefore capture the divider state, run its own divisions and then put the captured state back. Writing an operand or a result while a division is running abandons that division.

Top module: `intDivider`

## Requirements
- R1: Byte offsets decode as follows: 0x60 unsigned dividend, 0x64 unsigned divisor, 0x68 signed dividend, 0x6C signed divisor, 0x70 quotient, 0x74 remainder, 0x78 status. A write to any of the four operand offsets stores the word and starts a division.
- R2: The status READY flag reads 0 from the operand write until the result is complete. It reads 1 starting exactly 8 clock edges after the write edge.
- R3: The two dividend offsets share one storage register, and the two divisor offsets share another. A read through either offset returns the stored word.
- R4: The status word carries READY in bit 0 and DIRTY in bit 1, with all other bits 0. At completion it reads 3.
- R5: A quotient read clears DIRTY and leaves READY at 1. A remainder read leaves the status unchanged.
- R6: A write to the quotient or remainder offset loads that word into the result and makes the status read 3. If a division is running, it is abandoned.
- R7: An unsigned division returns the truncated quotient and a remainder smaller than the divisor.
- R8: A signed division truncates toward zero. A nonzero remainder takes the sign of the dividend.
- R9: When the divisor is zero, the remainder equals the dividend. The quotient is all ones for an unsigned division or a non-negative signed dividend, and 1 for a negative signed dividend.
- R10: After reset the divisor reads 1, and the dividend, quotient, remainder and status read 0.
- R11: An operand write during a running division restarts the count with the new operands. The result then follows the later operands and arrives 8 edges after the later write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Byte offset of the register accessed |
| busWrite | input | 1 | Write strobe, sampled on the rising clock edge |
| busRead | input | 1 | Read strobe; a quotient read takes effect at the clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |

## Verification
The hardest states to reach from the ports are the two interruptions of a division already in flight. One is a second operand write that must restart the count. The other is a direct result write that must stop the datapath from overwriting the restored word. The stimulus gets there by placing the second write a few cycles into a running division. It then samples the status on the exact edge where the original division would have finished, and again where the restarted one does. Completion flags are sampled one edge before and on the completing edge, so an off-by-one latency shows up. Sign corners, such as the most negative dividend and a zero divisor with either sign, come from the vector table.

// File: rtl/intDivPkg.sv
`timescale 1ns/1ps
package intDivPkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_U_DIVIDEND = 8'h60;
  localparam logic [ADDR_W-1:0] OFF_U_DIVISOR  = 8'h64;
  localparam logic [ADDR_W-1:0] OFF_S_DIVIDEND = 8'h68;
  localparam logic [ADDR_W-1:0] OFF_S_DIVISOR  = 8'h6C;
  localparam logic [ADDR_W-1:0] OFF_QUOTIENT   = 8'h70;
  localparam logic [ADDR_W-1:0] OFF_REMAINDER  = 8'h74;
  localparam logic [ADDR_W-1:0] OFF_STATUS     = 8'h78;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic loadDividend;
    logic loadDivisor;
    logic start;
    logic signedOp;
    logic step;
    logic finish;
    logic loadQuo;
    logic loadRem;
  } divStrobes_t;

endpackage

// File: rtl/divCtrl.sv
`timescale 1ns/1ps
module divCtrl
  import intDivPkg::*;
#(
  parameter int CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  output divStrobes_t       strobes,
  output logic              ready,
  output logic              dirty
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic busy;
  logic wrUDvd, wrUDvs, wrSDvd, wrSDvs, wrQuo, wrRem;
  logic quoRead;
  logic restore;

  assign wrUDvd  = busWrite && (busAddr == OFF_U_DIVIDEND);
  assign wrUDvs  = busWrite && (busAddr == OFF_U_DIVISOR);
  assign wrSDvd  = busWrite && (busAddr == OFF_S_DIVIDEND);
  assign wrSDvs  = busWrite && (busAddr == OFF_S_DIVISOR);
  assign wrQuo   = busWrite && (busAddr == OFF_QUOTIENT);
  assign wrRem   = busWrite && (busAddr == OFF_REMAINDER);
  assign quoRead = busRead  && (busAddr == OFF_QUOTIENT);
  assign restore = wrQuo || wrRem;
  assign busy    = (cnt != '0);

  always_comb begin
    strobes              = '0;
    strobes.loadDividend = wrUDvd || wrSDvd;
    strobes.loadDivisor  = wrUDvs || wrSDvs;
    strobes.start        = wrUDvd || wrSDvd || wrUDvs || wrSDvs;
    strobes.signedOp     = wrSDvd || wrSDvs;
    strobes.loadQuo      = wrQuo;
    strobes.loadRem      = wrRem;
    strobes.step         = busy && !strobes.start && !restore;
    strobes.finish       = strobes.step && (cnt == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobes.start) begin
      cnt <= CNT_W'(CYCLES);
    end else if (restore) begin
      cnt <= '0;
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ready <= 1'b0;
      dirty <= 1'b0;
    end else if (strobes.start) begin
      ready <= 1'b0;
      dirty <= 1'b0;
    end else if (restore || strobes.finish) begin
      ready <= 1'b1;
      dirty <= 1'b1;
    end else if (quoRead) begin
      dirty <= 1'b0;
    end
  end

  AST_DIRTY_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    dirty |-> ready); // R4
  AST_NOT_READY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ready); // R2
  AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.start |=> !ready); // R2
  AST_QUO_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (quoRead && !busWrite) |=> !dirty); // R5
  AST_RESTORE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (restore && !strobes.start) |=> (ready && dirty)); // R6

endmodule

// File: rtl/divDatapath.sv
`timescale 1ns/1ps
module divDatapath
  import intDivPkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobes_t       strobes,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              ready,
  input  logic              dirty,
  output logic [WIDTH-1:0]  rdata
);

  localparam int STEPS = WIDTH / CYCLES;

  logic [WIDTH-1:0] dividendReg, divisorReg;
  logic [WIDTH-1:0] quoReg, remReg, absDivisor;
  logic             negQ, negR;

  logic [WIDTH-1:0] newDividend, newDivisor, dvdMag, dvsMag;
  logic             dvdNeg, dvsNeg;
  logic [WIDTH-1:0] nextQ, nextR;

  assign newDividend = strobes.loadDividend ? wdata : dividendReg;
  assign newDivisor  = strobes.loadDivisor  ? wdata : divisorReg;
  assign dvdNeg      = strobes.signedOp && newDividend[WIDTH-1];
  assign dvsNeg      = strobes.signedOp && newDivisor[WIDTH-1];
  assign dvdMag      = dvdNeg ? (~newDividend + 1'b1) : newDividend;
  assign dvsMag      = dvsNeg ? (~newDivisor  + 1'b1) : newDivisor;

  // Several restoring steps per clock: shift one dividend bit into the
  // partial remainder, subtract the divisor when it fits.
  always_comb begin
    logic [WIDTH:0]   trial;
    logic [WIDTH-1:0] r, q;
    r = remReg;
    q = quoReg;
    for (int i = 0; i < STEPS; i++) begin
      trial = {r, q[WIDTH-1]};
      if (trial >= {1'b0, absDivisor}) begin
        trial = trial - {1'b0, absDivisor};
        q = {q[WIDTH-2:0], 1'b1};
      end else begin
        q = {q[WIDTH-2:0], 1'b0};
      end
      r = trial[WIDTH-1:0];
    end
    nextQ = q;
    nextR = r;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dividendReg <= '0;
      divisorReg  <= WIDTH'(1);
    end else begin
      if (strobes.loadDividend) dividendReg <= wdata;
      if (strobes.loadDivisor)  divisorReg  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoReg     <= '0;
      remReg     <= '0;
      absDivisor <= WIDTH'(1);
      negQ       <= 1'b0;
      negR       <= 1'b0;
    end else if (strobes.start) begin
      quoReg     <= dvdMag;
      remReg     <= '0;
      absDivisor <= dvsMag;
      negQ       <= dvdNeg ^ dvsNeg;
      negR       <= dvdNeg;
    end else if (strobes.loadQuo || strobes.loadRem) begin
      if (strobes.loadQuo) quoReg <= wdata;
      if (strobes.loadRem) remReg <= wdata;
    end else if (strobes.finish) begin
      quoReg <= negQ ? (~nextQ + 1'b1) : nextQ;
      remReg <= negR ? (~nextR + 1'b1) : nextR;
    end else if (strobes.step) begin
      quoReg <= nextQ;
      remReg <= nextR;
    end
  end

  always_comb begin
    case (busAddr)
      OFF_U_DIVIDEND, OFF_S_DIVIDEND: rdata = dividendReg;
      OFF_U_DIVISOR,  OFF_S_DIVISOR:  rdata = divisorReg;
      OFF_QUOTIENT:                   rdata = quoReg;
      OFF_REMAINDER:                  rdata = remReg;
      OFF_STATUS:                     rdata = {{(WIDTH-2){1'b0}}, dirty, ready};
      default:                        rdata = '0;
    endcase
  end

  AST_DIVISOR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadDivisor |=> $stable(divisorReg)); // R3
  AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && negR) |=> (remReg == '0 || remReg[WIDTH-1])); // R8
  AST_ZERO_DIV_REM: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && absDivisor == '0) |=> (remReg == dividendReg)); // R9
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && !negQ && !negR && absDivisor != '0) |=> (remReg < absDivisor)); // R7

endmodule

// File: rtl/intDivider.sv
`timescale 1ns/1ps
module intDivider
  import intDivPkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata
);

  divStrobes_t strobes;
  logic        ready, dirty;

  divCtrl #(.CYCLES(CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .strobes(strobes), .ready(ready), .dirty(dirty)
  );

  divDatapath #(.WIDTH(WIDTH), .CYCLES(CYCLES)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wdata(busWdata),
    .busAddr(busAddr), .ready(ready), .dirty(dirty), .rdata(busRdata)
  );

endmodule

// File: tb/intDivider_test.sv
`timescale 1ns/1ps
module intDivider_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWrite = 1'b0;
  logic        busRead = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  intDivider uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWdata(busWdata), .busRdata(busRdata)
  );

  // {signed, dividend, divisor, quotient, remainder}
  localparam logic [128:0] VECS [14] = '{
    {1'b1, 32'd123456,     32'hFFFFFEBF, 32'hFFFFFE80, 32'd192},
    {1'b1, 32'hFFFFF448,   32'd2,        32'hFFFFFA24, 32'd0},
    {1'b0, 32'd123456,     32'd321,      32'd384,      32'd192},
    {1'b0, 32'd123,        32'd7,        32'd17,       32'd4},
    {1'b0, 32'd123456,     32'd0,        32'hFFFFFFFF, 32'd123456},
    {1'b0, 32'h80000000,   32'd0,        32'hFFFFFFFF, 32'h80000000},
    {1'b1, 32'd3000,       32'd0,        32'hFFFFFFFF, 32'd3000},
    {1'b1, 32'hFFFFF448,   32'd0,        32'd1,        32'hFFFFF448},
    {1'b1, 32'h80000000,   32'd2,        32'hC0000000, 32'd0},
    {1'b0, 32'h80000000,   32'd2,        32'h40000000, 32'd0},
    {1'b1, 32'hFFFFFFF9,   32'd2,        32'hFFFFFFFD, 32'hFFFFFFFF},
    {1'b1, 32'd7,          32'hFFFFFFFE, 32'hFFFFFFFD, 32'd1},
    {1'b1, 32'h80000000,   32'hFFFFFFFF, 32'h80000000, 32'd0},
    {1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF, 32'd1,        32'd0}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRead = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRead = 1'b0;
  endtask

  initial begin
    #1000000;
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset values
    busRd(8'h60, v); check("R10", "dividend", v, 32'd0);
    busRd(8'h64, v); check("R10", "divisor", v, 32'd1);
    busRd(8'h70, v); check("R10", "quotient", v, 32'd0);
    busRd(8'h74, v); check("R10", "remainder", v, 32'd0);
    busRd(8'h78, v); check("R10", "status", v, 32'd0);

    // Vector table: R7 unsigned, R8 signed, R9 zero divisor
    for (int i = 0; i < 14; i++) begin
      logic        sgn;
      string       req;
      logic [31:0] dvd, dvs, eq, er;
      {sgn, dvd, dvs, eq, er} = VECS[i];
      req = (dvs == 0) ? "R9" : (sgn ? "R8" : "R7");
      busWr(sgn ? 8'h68 : 8'h60, dvd);
      busWr(sgn ? 8'h6C : 8'h64, dvs);
      repeat (8) @(negedge clk);
      busRd(8'h78, v); check("R4", "status at completion", v, 32'd3);
      busRd(8'h74, v); check(req, "remainder", v, er);
      busRd(8'h78, v); check("R5", "status after remainder read", v, 32'd3);
      busRd(8'h70, v); check(req, "quotient", v, eq);
      busRd(8'h78, v); check("R5", "status after quotient read", v, 32'd1);
      // R3 both aliases return the shared operand
      busRd(sgn ? 8'h60 : 8'h68, v); check("R3", "dividend other alias", v, dvd);
      busRd(sgn ? 8'h64 : 8'h6C, v); check("R3", "divisor other alias", v, dvs);
    end

    // R2 exact latency; R1 operand write starts a division
    busWr(8'h60, 32'd1000);
    busWr(8'h64, 32'd9);
    busAddr = 8'h78; busRead = 1'b1;
    for (int k = 0; k <= 8; k++) begin
      #1 check("R2", $sformatf("ready after %0d edges", k), {31'd0, busRdata[0]},
               (k >= 8) ? 32'd1 : 32'd0);
      @(negedge clk);
    end
    busRead = 1'b0;
    busRd(8'h70, v); check("R1", "quotient 1000/9", v, 32'd111);
    busRd(8'h74, v); check("R1", "remainder 1000/9", v, 32'd1);

    // R11 restart by operand write mid-division
    busWr(8'h60, 32'd100);
    busWr(8'h64, 32'd7);
    repeat (3) @(negedge clk);
    busWr(8'h64, 32'd10);
    repeat (7) @(negedge clk);
    busAddr = 8'h78; busRead = 1'b1;
    #1 check("R11", "status one edge before restarted end", busRdata, 32'd0);
    @(negedge clk);
    #1 check("R11", "status at restarted end", busRdata, 32'd3);
    busRead = 1'b0;
    busRd(8'h70, v); check("R11", "quotient 100/10", v, 32'd10);
    busRd(8'h74, v); check("R11", "remainder 100/10", v, 32'd0);

    // R6 restore after completion
    busWr(8'h70, 32'hFFFFFE80);
    busRd(8'h78, v); check("R6", "status after quotient write", v, 32'd3);
    busWr(8'h74, 32'd192);
    busRd(8'h74, v); check("R6", "restored remainder", v, 32'd192);
    busRd(8'h70, v); check("R6", "restored quotient", v, 32'hFFFFFE80);
    busRd(8'h78, v); check("R5", "status after restored quotient read", v, 32'd1);

    // R6 restore aborts a running division
    busWr(8'h60, 32'd1000);
    busWr(8'h64, 32'd3);
    repeat (2) @(negedge clk);
    busWr(8'h70, 32'h00001234);
    repeat (12) @(negedge clk);
    busRd(8'h78, v); check("R6", "status after abort", v, 32'd3);
    busRd(8'h70, v); check("R6", "quotient kept after abort", v, 32'h00001234);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule